// File: doc/BRIEF.md
# Clocked Serial Shift Interface Controller

This block runs an 8-bit synchronous serial link over three wires: a shift clock, a data output and a data input. One state machine sequences each transfer. A bit counter tracks progress, and a sticky interrupt request reports when a transfer ends. The clock can come from an internal divider of the system clock, and in that case the block drives it. The clock can also come from the far end, and in that case it is synchronised and edge-detected. Data leaves least significant bit first on falling clock edges, and the input is sampled on rising edges.

Software arms a transfer in two steps. It first writes the mode register, which selects the clock source and a 2-bit port mode field and also restarts the interface. It then issues a start strobe. The start strobe only arms the block: the transfer begins on the first falling clock edge that follows. The states are start-wait, clock-wait, transfer and free-run. Free-run is a clock-only state and exists only with the internal clock.

The transitions are:

- reset-entry: into start-wait.
- arm: start-wait to clock-wait, on the start strobe.
- launch: clock-wait to transfer, on a falling edge.
- freerun-entry: clock-wait to free-run, on a falling edge, internal clock with port mode 00.
- complete: transfer to start-wait, after eight rising edges.
- restart-abort: transfer to clock-wait, on the start strobe.
- mode-restart: any state to start-wait, on a mode register write.

Top module: `sio_ctrl`

## Requirements
- R1: After reset the block is in start-wait with irq low, so equal to idle_lvl and sck_out high. The mode defaults to the external clock (mode_ext=1) with port mode 01, so sck_oe is low.
- R2: A mode_wr pulse latches mode_ext and mode_pm and moves the block from any state to start-wait. Clock edges that arrive afterwards, with no start, change neither so nor irq.
- R3: In start-wait, clock edges are ignored. A start pulse moves the block to clock-wait, and no bit counting begins before that.
- R4: In clock-wait, the first falling clock edge enters transfer. so then presents tx bit 0 and advances one bit per falling edge. si is sampled on each rising edge and shifted in from the top, so the first received bit ends in rx_data bit 0. tx_wr loads tx_data whenever the block is not in transfer.
- R5: The eighth rising edge in transfer returns the block to start-wait with the counter at 0 and irq set. rx_data then holds the received byte.
- R6: A start pulse during transfer aborts it: irq is set, the counter clears and the block goes to clock-wait. A following transfer again moves a full 8 bits.
- R7: A mode_wr pulse during transfer aborts it, sets irq and returns the block to start-wait.
- R8: With the internal clock (mode_ext=0), sck_oe is high. sck_out toggles every CLK_DIV system clocks in clock-wait, transfer and free-run, and is held high in start-wait.
- R9: With the internal clock and mode_pm=00, the first falling edge in clock-wait enters free-run. There sck_out keeps toggling, no data shifts and irq is not set, and a mode_wr ends it. With the external clock, mode_pm=00 gives a normal transfer.
- R10: so equals idle_lvl in start-wait, clock-wait and free-run. In transfer, idle_lvl has no effect on so.
- R11: irq stays high until an irq_clr pulse clears it. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe; restarts the interface |
| mode_ext | input | 1 | Clock source written by mode_wr: 1 external, 0 internal |
| mode_pm | input | 2 | Port mode field written by mode_wr; 00 selects free-run with the internal clock |
| start | input | 1 | Start strobe |
| tx_wr | input | 1 | Load strobe for transmit data |
| tx_data | input | 8 | Transmit byte |
| idle_lvl | input | 1 | Level driven on so outside transfer |
| irq_clr | input | 1 | Clears the interrupt request |
| sck_in | input | 1 | External serial clock |
| si | input | 1 | Serial data in |
| sck_out | output | 1 | Internal serial clock |
| sck_oe | output | 1 | Output enable for sck_out (internal clock selected) |
| so | output | 1 | Serial data out |
| rx_data | output | 8 | Received byte |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench sends clock edges in start-wait and checks that a later transfer still moves the loaded byte intact. A design that counted those edges would send a shifted or truncated byte. It aborts transfers mid-byte with both the start strobe and a mode write, then checks that irq rises and that the next transfer moves all 8 bits. A counter that survived the abort would end that transfer early. It toggles idle_lvl during a transfer, where a wrong output mux would corrupt the serial bits. It also checks that port mode 00 yields a clock-only free-run with no interrupt under the internal clock, but a normal transfer under the external clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_STARTW = 2'd0,
        ST_CLKW   = 2'd1,
        ST_XFER   = 2'd2,
        ST_FREE   = 2'd3
    } sio_state_e;

    localparam logic [1:0] PM_FREERUN = 2'b00;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
    parameter int CLK_DIV = 4,
    parameter int SYNC_N  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic run,
    input  logic sck_in,
    output logic sck_out,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0]  div_q;
    logic              sck_q;
    logic              tick;
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              synced;

    assign tick = run && (div_q == DIV_LAST);

    // internal divider: clock parked high while not running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (!run) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // synchroniser chain for the external clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], sck_in};
            prev_q <= synced;
        end
    end

    assign synced  = sync_q[SYNC_N-1];
    assign sck_out = sck_q;
    assign fall_ev = ext_mode ? (prev_q & ~synced) : (tick & sck_q);
    assign rise_ev = ext_mode ? (~prev_q & synced) : (tick & ~sck_q);
endmodule

// File: rtl/sio_fsm.sv
module sio_fsm
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic       start,
    input  logic       ext_mode,
    input  logic [1:0] pmode,
    input  logic       fall_ev,
    input  logic       rise_ev,
    input  logic       last_bit,
    output sio_state_e state,
    output logic       xfer_end,
    output logic       in_xfer,
    output logic       armed
);
    sio_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STARTW;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (mode_wr) begin
            nxt = ST_STARTW;
        end else begin
            unique case (state)
                ST_STARTW: if (start) nxt = ST_CLKW;
                ST_CLKW: begin
                    if (fall_ev)
                        nxt = (!ext_mode && pmode == PM_FREERUN) ? ST_FREE : ST_XFER;
                end
                ST_XFER: begin
                    if (start)                     nxt = ST_CLKW;
                    else if (rise_ev && last_bit)  nxt = ST_STARTW;
                end
                ST_FREE: nxt = ST_FREE;
            endcase
        end
    end

    always_comb begin
        in_xfer  = (state == ST_XFER);
        armed    = (state == ST_CLKW) || (state == ST_XFER);
        xfer_end = (state == ST_XFER) && (nxt != ST_XFER);
    end
endmodule

// File: rtl/sio_shift.sv
module sio_shift #(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clr,
    input  logic              active,
    input  logic              armed,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              si,
    output logic [CNT_W-1:0]  cnt,
    output logic              last_bit,
    output logic              so_bit,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (clr)               cnt <= '0;
        else if (active && rise_ev) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sr_q <= '0;
        else if (load)              sr_q <= load_data;
        else if (active && rise_ev) sr_q <= {si, sr_q[DATA_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 so_bit <= 1'b1;
        else if (armed && fall_ev)  so_bit <= sr_q[0];
    end

    assign last_bit = (cnt == CNT_W'(DATA_W - 1));
    assign rx_data  = sr_q;
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
    import sio_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4,
    parameter int SYNC_N  = 2,
    localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              mode_ext,
    input  logic [1:0]        mode_pm,
    input  logic              start,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              idle_lvl,
    input  logic              irq_clr,
    input  logic              sck_in,
    input  logic              si,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              so,
    output logic [DATA_W-1:0] rx_data,
    output logic              irq
);
    sio_state_e       state;
    logic             mode_ext_q;
    logic [1:0]       mode_pm_q;
    logic             fall_ev, rise_ev;
    logic             xfer_end, in_xfer, armed;
    logic             last_bit, so_bit;
    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_ext_q <= 1'b1;
            mode_pm_q  <= 2'b01;
        end else if (mode_wr) begin
            mode_ext_q <= mode_ext;
            mode_pm_q  <= mode_pm;
        end
    end

    sio_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_N(SYNC_N)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (mode_ext_q),
        .run      (!mode_ext_q && state != ST_STARTW),
        .sck_in   (sck_in),
        .sck_out  (sck_out),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev)
    );

    sio_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .start    (start),
        .ext_mode (mode_ext_q),
        .pmode    (mode_pm_q),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .last_bit (last_bit),
        .state    (state),
        .xfer_end (xfer_end),
        .in_xfer  (in_xfer),
        .armed    (armed)
    );

    sio_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_wr && !in_xfer),
        .load_data (tx_data),
        .clr       (xfer_end || !in_xfer),
        .active    (in_xfer),
        .armed     (armed),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .si        (si),
        .cnt       (bit_cnt),
        .last_bit  (last_bit),
        .so_bit    (so_bit),
        .rx_data   (rx_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        irq <= 1'b0;
        else if (xfer_end) irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

    assign so     = in_xfer ? so_bit : idle_lvl;
    assign sck_oe = !mode_ext_q;
endmodule

// File: rtl/sio_chk.sv
module sio_chk
    import sio_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic             start,
    input sio_state_e       state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             irq,
    input logic             sck_out,
    input logic             mode_ext_q
);
    // R2
    restart_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> state == ST_STARTW);

    // R3
    startw_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STARTW && !start && !mode_wr) |=> state == ST_STARTW);

    // R4
    idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STARTW || state == ST_CLKW) |-> bit_cnt == '0);

    // R5
    irq_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_XFER && state != ST_XFER) |-> irq);

    // R8
    sck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_STARTW && state == ST_STARTW) |-> sck_out);

    // R9
    free_internal_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FREE |-> !mode_ext_q);
endmodule

bind sio_ctrl sio_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .start      (start),
    .state      (state),
    .bit_cnt    (bit_cnt),
    .irq        (irq),
    .sck_out    (sck_out),
    .mode_ext_q (mode_ext_q)
);

// File: tb/test_sio_ctrl.sv
module test_sio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n, mode_wr, mode_ext, start, tx_wr, idle_lvl, irq_clr, sck_in, si;
    logic [1:0] mode_pm;
    logic [7:0] tx_data, rx_data, got;
    logic       sck_out, sck_oe, so, irq;

    int total = 0;
    int bad   = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_ctrl #(.DATA_W(8), .CLK_DIV(4), .SYNC_N(2)) i_sio_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_ext(mode_ext),
        .mode_pm(mode_pm), .start(start), .tx_wr(tx_wr), .tx_data(tx_data),
        .idle_lvl(idle_lvl), .irq_clr(irq_clr), .sck_in(sck_in), .si(si),
        .sck_out(sck_out), .sck_oe(sck_oe), .so(so), .rx_data(rx_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_mode(input logic ext, input logic [1:0] pm);
        @(negedge clk); mode_wr = 1'b1; mode_ext = ext; mode_pm = pm;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_data = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // external clock driver: n bits, optional idle_lvl toggling
    task automatic ext_bits(input logic [7:0] rxp, input int n, input bit tog,
                            output logic [7:0] cap);
        cap = '0;
        for (int i = 0; i < n; i++) begin
            sck_in = 1'b0;
            if (tog) idle_lvl = ~idle_lvl;
            wait_clks(HALF);
            cap[i] = so;
            si = rxp[i];
            sck_in = 1'b1;
            wait_clks(HALF);
        end
        idle_lvl = 1'b1;
    endtask

    // internal clock: sample so while sck_out is low, then set si
    task automatic int_bits(input logic [7:0] rxp, output logic [7:0] cap);
        cap = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge sck_out);
            wait_clks(2);
            cap[i] = so;
            si = rxp[i];
        end
    endtask

    function automatic int count_rises_dummy(input int x);
        return x;
    endfunction

    // monitor: compare rx_data on each irq rise against the scoreboard
    initial begin
        forever begin
            @(posedge irq);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected irq", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e >= 0) check(rx_data == e[7:0], "R5 rx_data at completion", rx_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int rises;
        logic prev;
        rst_n = 0; mode_wr = 0; mode_ext = 1; mode_pm = 2'b01; start = 0;
        tx_wr = 0; tx_data = 0; idle_lvl = 1; irq_clr = 0; sck_in = 1; si = 0;
        wait_clks(5);
        check(so == 1'b1, "R1 so idle after reset", so, 1);
        check(irq == 1'b0, "R1 irq low after reset", irq, 0);
        check(sck_out == 1'b1, "R1 sck_out high after reset", sck_out, 1);
        check(sck_oe == 1'b0, "R1 sck_oe low (external default)", sck_oe, 0);
        rst_n = 1;
        wait_clks(2);

        // R10 idle level follows idle_lvl in start-wait
        idle_lvl = 0; wait_clks(1);
        check(so == 1'b0, "R10 so follows idle_lvl", so, 0);
        idle_lvl = 1; wait_clks(1);

        // R3: stray clocks in start-wait, then a full external transfer
        do_mode(1'b1, 2'b01);
        do_load(8'hA5);
        ext_bits(8'h00, 3, 1'b0, got);
        check(so == 1'b1 && irq == 1'b0, "R3 clocks ignored in start-wait", {irq, so}, 1);
        do_start();
        wait_clks(1);
        check(so == 1'b1, "R10 so idle in clock-wait", so, 1);
        exp_q.push_back(8'h3C);
        ext_bits(8'h3C, 8, 1'b0, got);
        check(got == 8'hA5, "R4 so bits lsb first", got, 8'hA5);
        check(irq == 1'b1, "R5 irq after 8 clocks", irq, 1);
        check(so == 1'b1, "R5 back to idle output", so, 1);
        do_clear();
        ext_bits(8'hFF, 2, 1'b0, got);
        check(irq == 1'b0, "R11 irq cleared and stays low", irq, 0);

        // R10: idle_lvl toggled during transfer has no effect
        do_load(8'h0F);
        do_start();
        exp_q.push_back(8'h81);
        ext_bits(8'h81, 8, 1'b1, got);
        check(got == 8'h0F, "R10 idle_lvl ignored in transfer", got, 8'h0F);

        // R6: start aborts a transfer
        do_clear();
        do_load(8'h55);
        do_start();
        exp_q.push_back(-1);
        ext_bits(8'h00, 3, 1'b0, got);
        check(irq == 1'b0, "R6 no irq mid transfer", irq, 0);
        do_start();
        wait_clks(2);
        check(irq == 1'b1, "R6 irq on start abort", irq, 1);
        check(so == 1'b1, "R6 idle output in clock-wait", so, 1);
        do_clear();
        do_load(8'hC3);
        exp_q.push_back(8'h96);
        ext_bits(8'h96, 8, 1'b0, got);
        check(got == 8'hC3, "R6 full byte after abort", got, 8'hC3);
        check(irq == 1'b1, "R6 irq after full byte", irq, 1);

        // R7: mode write aborts a transfer
        do_clear();
        do_load(8'hF0);
        do_start();
        exp_q.push_back(-1);
        ext_bits(8'h00, 4, 1'b0, got);
        do_mode(1'b1, 2'b01);
        wait_clks(2);
        check(irq == 1'b1, "R7 irq on mode write abort", irq, 1);
        check(so == 1'b1, "R7 idle output in start-wait", so, 1);
        do_clear();
        ext_bits(8'hFF, 8, 1'b0, got);
        check(irq == 1'b0 && so == 1'b1, "R2 no transfer without start", {irq, so}, 1);

        // R9: external clock with port mode 00 still transfers
        do_mode(1'b1, 2'b00);
        do_load(8'h3A);
        do_start();
        exp_q.push_back(8'h5C);
        ext_bits(8'h5C, 8, 1'b0, got);
        check(got == 8'h3A, "R9 external 00 is a normal transfer", got, 8'h3A);

        // R8: internal clock transfer
        do_clear();
        do_mode(1'b0, 2'b01);
        check(sck_oe == 1'b1, "R8 sck_oe high in internal mode", sck_oe, 1);
        rises = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sck_out != 1'b1) rises++;
        end
        check(rises == 0, "R8 sck parked in start-wait", rises, 0);
        do_load(8'h6B);
        exp_q.push_back(8'hD2);
        fork
            do_start();
            int_bits(8'hD2, got);
        join
        wait_clks(4);
        check(got == 8'h6B, "R8 internal clock so bits", got, 8'h6B);
        check(irq == 1'b1, "R8 irq after internal transfer", irq, 1);
        rises = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sck_out != 1'b1) rises++;
        end
        check(rises == 0, "R8 sck parked after transfer", rises, 0);

        // R9: free-run clock-only state
        do_clear();
        do_mode(1'b0, 2'b00);
        do_start();
        rises = 0; prev = sck_out;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (sck_out && !prev) rises++;
            prev = sck_out;
        end
        check(rises >= 8 && rises <= 11, "R9 free-run clock toggles", rises, 10);
        check(irq == 1'b0, "R9 no irq in free-run", irq, 0);
        check(rx_data == 8'hD2, "R9 no shifting in free-run", rx_data, 8'hD2);
        idle_lvl = 0; wait_clks(1);
        check(so == 1'b0, "R10 so follows idle_lvl in free-run", so, 0);
        idle_lvl = 1;
        do_mode(1'b0, 2'b01);
        wait_clks(1);
        rises = 0; prev = sck_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck_out && !prev) rises++;
            prev = sck_out;
        end
        check(rises == 0 && sck_out == 1'b1, "R2 mode write ends free-run", rises, 0);

        check(exp_q.size() == 0, "R5 all expected transfers seen", exp_q.size(), 0);
        wait_clks(2);
        finish_run();
    end
endmodule